// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. Software places the page frame number of the top-level table (the directory) on `root_frame`. For each accepted request the walker fetches the directory entry, then (unless that entry maps a 4 MB region on its own) the second-level entry, and returns either a physical address or a fault code that says what went wrong and at which level. Pages are 4 KB. Each table page holds 1024 four-byte entries, so the virtual address splits into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit offset (bits 11:0).

Entry word layout: bits 31:12 frame base, bit 0 valid, bit 1 write permitted, bit 7 (directory level only) maps a 4 MB region. The physical address is made by substituting frame bits for upper virtual bits. Nothing is added. Only one walk runs at a time. Memory reads go through a request/ready port with a separate read-data valid strobe, and the latency may vary.

States: `W_IDLE` (waits for a request), `W_DIR_ISSUE` (offers the directory read), `W_DIR_WAIT` (waits for directory data), `W_TBL_ISSUE` (offers the table read), `W_TBL_WAIT` (waits for table data), `W_REPLY` (holds the result). Transitions: IDLE→DIR_ISSUE on request accept. DIR_ISSUE→DIR_WAIT on read accept. DIR_WAIT→REPLY on fault or 4 MB entry, →TBL_ISSUE otherwise. TBL_ISSUE→TBL_WAIT on read accept. TBL_WAIT→REPLY on data. REPLY→IDLE on `resp_ready`.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0.
- R2: The first read of a walk goes to address `{root_frame, 12'h000} + vaddr[31:22]*4`.
- R3: For a valid, non-4 MB directory entry D that allows the access, the second read goes to `{D[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: A successful two-level walk returns `{T[31:12], vaddr[11:0]}`, where T is the table entry. Bit 7 of a table entry has no effect.
- R5: A valid directory entry with bit 7 set ends the walk after one read and returns `{D[31:22], vaddr[21:0]}`.
- R6: A directory entry with bit 0 clear ends the walk after one read with fault code 1 (not valid) and level 0.
- R7: A table entry with bit 0 clear returns fault code 1 and level 1.
- R8: A write (`req_write`=1) through an entry whose bit 1 is clear returns fault code 2 (write denied) with that entry's level: 0 for the directory, 1 for the table. A missing valid bit takes priority. Reads never get code 2.
- R9: From request accept until the result is taken, `req_ready` stays 0 and requests offered meanwhile have no effect.
- R10: While `resp_valid` is 1 and `resp_ready` is 0, the result outputs hold steady.
- R11: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the read request and its address hold steady.
- R12: A successful result reports fault code 0. A faulting result reports physical address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_frame | input | 20 | Frame number of the directory page |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| resp_valid | output | 1 | Result available |
| resp_ready | input | 1 | Consumer takes the result |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 2 | 0 none, 1 not valid, 2 write denied |
| resp_level | output | 1 | Level of the faulting entry: 0 directory, 1 table |
| mem_req_valid | output | 1 | Entry read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry word |

## Verification
A wrong state register shows up at the memory port first. A stray second read after a 4 MB or faulting directory entry, a missing table read, or a read to the wrong address becomes visible within a cycle of the directory data returning. It is caught by comparing the number and addresses of the reads against the arithmetic expectation. A corrupted capture register shows up at the reply in the same walk, as a wrong frame, a wrong kept offset, a wrong fault code or a wrong level. The sweep covers every combination of entry kind, access type and read latency, so each branch out of both wait states is taken under several timings.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        W_IDLE      = 3'd0,
        W_DIR_ISSUE = 3'd1,
        W_DIR_WAIT  = 3'd2,
        W_TBL_ISSUE = 3'd3,
        W_TBL_WAIT  = 3'd4,
        W_REPLY     = 3'd5
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_e;

endpackage

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int ENTRY_W     = 32,
    parameter int VALID_BIT   = 0,
    parameter int WRITE_BIT   = 1,
    parameter int HUGE_BIT    = 7,
    parameter bit IS_DIR      = 1'b1
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic               is_write,
    output fault_e             verdict,
    output logic               is_huge
);

    logic unused_entry_bits;
    assign unused_entry_bits = ^entry;

    always_comb begin
        if (!entry[VALID_BIT]) begin
            verdict = FLT_ABSENT;
        end else if (is_write && !entry[WRITE_BIT]) begin
            verdict = FLT_PROT;
        end else begin
            verdict = FLT_NONE;
        end
    end

    generate
        if (IS_DIR) begin : g_dir_level
            assign is_huge = entry[VALID_BIT] & entry[HUGE_BIT];
        end else begin : g_leaf_level
            assign is_huge = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [PA_W-OFF_W-1:0] root_frame,
    input  logic [PA_W-OFF_W-1:0] dir_frame,
    input  logic [VA_W-1:0]       vaddr,
    input  logic [PA_W-1:0]       live_entry,
    output logic [PA_W-1:0]       dir_entry_addr,
    output logic [PA_W-1:0]       tbl_entry_addr,
    output logic [PA_W-1:0]       leaf_paddr,
    output logic [PA_W-1:0]       huge_paddr
);

    localparam int SH       = $clog2(ENTRY_BYTES);
    localparam int HUGE_OFF = OFF_W + IDX_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    assign dir_idx = vaddr[VA_W-1 -: IDX_W];
    assign tbl_idx = vaddr[HUGE_OFF-1 -: IDX_W];

    assign dir_entry_addr = {root_frame, {OFF_W{1'b0}}} + (PA_W'(dir_idx) << SH);
    assign tbl_entry_addr = {dir_frame,  {OFF_W{1'b0}}} + (PA_W'(tbl_idx) << SH);

    assign leaf_paddr = {live_entry[PA_W-1:OFF_W],    vaddr[OFF_W-1:0]};
    assign huge_paddr = {live_entry[PA_W-1:HUGE_OFF], vaddr[HUGE_OFF-1:0]};

    logic unused_live_low;
    assign unused_live_low = ^live_entry[OFF_W-1:0];

endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
    import ptw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    output logic                  req_ready,
    output logic                  resp_valid,
    input  logic                  resp_ready,
    output logic [PA_W-1:0]       resp_paddr,
    output logic [1:0]            resp_fault,
    output logic                  resp_level,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [PA_W-1:0]       mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [PA_W-1:0]       mem_rsp_data,
    input  fault_e                dir_verdict,
    input  logic                  dir_huge,
    input  fault_e                tbl_verdict,
    input  logic [PA_W-1:0]       dir_entry_addr,
    input  logic [PA_W-1:0]       tbl_entry_addr,
    input  logic [PA_W-1:0]       leaf_paddr,
    input  logic [PA_W-1:0]       huge_paddr,
    output logic [VA_W-1:0]       vaddr_q,
    output logic                  write_q,
    output logic [PA_W-OFF_W-1:0] dir_frame_q
);

    walk_state_e state_q, state_d;
    logic [PA_W-1:0] paddr_q;
    fault_e          fault_q;
    logic            level_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:      if (req_valid)     state_d = W_DIR_ISSUE;
            W_DIR_ISSUE: if (mem_req_ready) state_d = W_DIR_WAIT;
            W_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (dir_verdict != FLT_NONE || dir_huge) state_d = W_REPLY;
                    else                                     state_d = W_TBL_ISSUE;
                end
            end
            W_TBL_ISSUE: if (mem_req_ready) state_d = W_TBL_WAIT;
            W_TBL_WAIT:  if (mem_rsp_valid) state_d = W_REPLY;
            W_REPLY:     if (resp_ready)    state_d = W_IDLE;
            default:                        state_d = W_IDLE;
        endcase
    end

    // captured walk context and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            write_q     <= 1'b0;
            dir_frame_q <= '0;
            paddr_q     <= '0;
            fault_q     <= FLT_NONE;
            level_q     <= 1'b0;
        end else begin
            unique case (state_q)
                W_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        write_q <= req_write;
                        paddr_q <= '0;
                        fault_q <= FLT_NONE;
                        level_q <= 1'b0;
                    end
                end
                W_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        dir_frame_q <= mem_rsp_data[PA_W-1:OFF_W];
                        if (dir_verdict != FLT_NONE) begin
                            fault_q <= dir_verdict;
                            level_q <= 1'b0;
                        end else if (dir_huge) begin
                            paddr_q <= huge_paddr;
                        end
                    end
                end
                W_TBL_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (tbl_verdict != FLT_NONE) begin
                            fault_q <= tbl_verdict;
                            level_q <= 1'b1;
                        end else begin
                            paddr_q <= leaf_paddr;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == W_IDLE);
        mem_req_valid = (state_q == W_DIR_ISSUE) || (state_q == W_TBL_ISSUE);
        mem_req_addr  = '0;
        if (state_q == W_DIR_ISSUE) mem_req_addr = dir_entry_addr;
        if (state_q == W_TBL_ISSUE) mem_req_addr = tbl_entry_addr;
        resp_valid    = (state_q == W_REPLY);
        resp_paddr    = paddr_q;
        resp_fault    = fault_q;
        resp_level    = level_q;
    end

    AST_PROT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == FLT_PROT) |-> write_q); // R8

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == FLT_NONE) |-> resp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]); // R4

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != FLT_NONE) |-> resp_paddr == '0); // R12

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4,
    parameter int VALID_BIT   = 0,
    parameter int WRITE_BIT   = 1,
    parameter int HUGE_BIT    = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PA_W-OFF_W-1:0] root_frame,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    output logic                  resp_valid,
    input  logic                  resp_ready,
    output logic [PA_W-1:0]       resp_paddr,
    output logic [1:0]            resp_fault,
    output logic                  resp_level,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [PA_W-1:0]       mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [PA_W-1:0]       mem_rsp_data
);

    localparam int LEVELS  = 2;
    localparam int FRAME_W = PA_W - OFF_W;

    fault_e              verdict [LEVELS];
    logic   [LEVELS-1:0] huge;
    logic   [VA_W-1:0]   vaddr_q;
    logic                write_q;
    logic   [FRAME_W-1:0] dir_frame_q;
    logic   [PA_W-1:0]   dir_entry_addr, tbl_entry_addr, leaf_paddr, huge_paddr;

    generate
        for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
            ptw_entry_check #(
                .ENTRY_W  (PA_W),
                .VALID_BIT(VALID_BIT),
                .WRITE_BIT(WRITE_BIT),
                .HUGE_BIT (HUGE_BIT),
                .IS_DIR   (lv == 0)
            ) i_check (
                .entry   (mem_rsp_data),
                .is_write(write_q),
                .verdict (verdict[lv]),
                .is_huge (huge[lv])
            );
        end
    endgenerate

    logic unused_leaf_huge;
    assign unused_leaf_huge = huge[1];

    ptw_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) i_addr (
        .root_frame    (root_frame),
        .dir_frame     (dir_frame_q),
        .vaddr         (vaddr_q),
        .live_entry    (mem_rsp_data),
        .dir_entry_addr(dir_entry_addr),
        .tbl_entry_addr(tbl_entry_addr),
        .leaf_paddr    (leaf_paddr),
        .huge_paddr    (huge_paddr)
    );

    ptw_walk_fsm #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .req_ready     (req_ready),
        .resp_valid    (resp_valid),
        .resp_ready    (resp_ready),
        .resp_paddr    (resp_paddr),
        .resp_fault    (resp_fault),
        .resp_level    (resp_level),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .dir_verdict   (verdict[0]),
        .dir_huge      (huge[0]),
        .tbl_verdict   (verdict[1]),
        .dir_entry_addr(dir_entry_addr),
        .tbl_entry_addr(tbl_entry_addr),
        .leaf_paddr    (leaf_paddr),
        .huge_paddr    (huge_paddr),
        .vaddr_q       (vaddr_q),
        .write_q       (write_q),
        .dir_frame_q   (dir_frame_q)
    );

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr)
                                         && $stable(resp_fault) && $stable(resp_level))); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid || mem_req_valid) |-> !req_ready); // R9

    AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid && !resp_valid)); // R2

    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_fault != 2'd3)); // R12

endmodule

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;

    localparam logic [19:0] ROOT = 20'h00100;
    localparam logic [19:0] TBL0 = 20'h00200;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_vaddr;
    logic        resp_valid, resp_ready, resp_level;
    logic [31:0] resp_paddr;
    logic [1:0]  resp_fault;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_rsp_data;

    int checks = 0;
    int fails  = 0;
    int rd_count = 0;
    int lat_sel  = 0;
    int addr_wobble = 0;
    logic [31:0] rd_addr [2];

    always #2.5 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst_n(rst_n), .root_frame(ROOT),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .resp_level(resp_level),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // directory contents: kind chosen by d mod 8
    function automatic logic [31:0] dir_word(input int d);
        logic [9:0] dd;
        dd = d[9:0];
        case (d % 8)
            3:       return {20'h00000, 12'h000};
            4:       return {dd ^ 10'h155, 10'h000, 12'h083};
            5:       return {dd ^ 10'h0AA, 10'h000, 12'h081};
            6:       return {TBL0 + 20'(d), 12'h001};
            default: return {TBL0 + 20'(d), 12'h003};
        endcase
    endfunction

    // table contents: kind chosen by t mod 4
    function automatic logic [31:0] tbl_word(input int d, input int t);
        logic [19:0] fr;
        fr = {2'b10, d[7:0], t[9:0]};
        case (t % 4)
            0:       return {fr, 12'h002};
            2:       return {fr, 12'h001};
            3:       return {fr, 12'h083};
            default: return {fr, 12'h003};
        endcase
    endfunction

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (a[31:12] == ROOT) return dir_word(int'(a[11:2]));
        if (a[31:12] >= TBL0 && a[31:12] < TBL0 + 20'd1024)
            return tbl_word(int'(a[31:12] - TBL0), int'(a[11:2]));
        return 32'hDEAD_0000;
    endfunction

    // memory model with varying accept and data latency
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                logic [31:0] a;
                a = mem_req_addr;
                for (int i = 0; i < lat_sel % 3; i++) begin
                    @(negedge clk);
                    if (!mem_req_valid || mem_req_addr !== a) addr_wobble++;
                end
                mem_req_ready = 1'b1;
                if (rd_count < 2) rd_addr[rd_count] = a;
                rd_count++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int i = 0; i < (lat_sel + 1) % 4; i++) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_read(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 32'h5A5A_5A5A;
                lat_sel++;
            end
        end
    end

    task automatic run_walk(input int d, input int t, input logic [11:0] off, input bit wr, input bit hold);
        logic [31:0] va, pde, pte, exp_pa, dir_a, tbl_a;
        logic [1:0]  exp_f;
        logic        exp_l;
        int          exp_reads;
        va    = {d[9:0], t[9:0], off};
        pde   = dir_word(d);
        dir_a = {ROOT, 12'h000} + 32'(d * 4);
        tbl_a = {pde[31:12], 12'h000} + 32'(t * 4);
        exp_pa = '0; exp_f = 2'd0; exp_l = 1'b0; exp_reads = 1;
        if (!pde[0])               begin exp_f = 2'd1; end
        else if (wr && !pde[1])    begin exp_f = 2'd2; end
        else if (pde[7])           begin exp_pa = {pde[31:22], va[21:0]}; end
        else begin
            exp_reads = 2;
            pte = tbl_word(d, t);
            exp_l = 1'b1;
            if (!pte[0])            exp_f = 2'd1;
            else if (wr && !pte[1]) exp_f = 2'd2;
            else begin exp_pa = {pte[31:12], va[11:0]}; exp_l = 1'b0; end
        end

        @(negedge clk);
        rd_count  = 0;
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        // busy: offer a different request that must have no effect
        req_vaddr = ~va; req_write = ~wr;
        check(req_ready == 1'b0, "R9 ready low after accept", 32'(req_ready), 32'd0);
        while (!resp_valid) @(negedge clk);
        check(req_ready == 1'b0, "R9 ready low with result", 32'(req_ready), 32'd0);
        req_valid = 1'b0;

        check(rd_count == exp_reads, "R5/R6 read count", 32'(rd_count), 32'(exp_reads));
        check(rd_addr[0] == dir_a, "R2 directory entry address", rd_addr[0], dir_a);
        if (exp_reads == 2)
            check(rd_addr[1] == tbl_a, "R3 table entry address", rd_addr[1], tbl_a);
        if (exp_f == 2'd1 && !exp_l)
            check(resp_fault == 2'd1 && resp_level == 1'b0, "R6 directory absent", {resp_fault, 29'd0, resp_level}, 32'h4000_0000);
        else if (exp_f == 2'd1)
            check(resp_fault == 2'd1 && resp_level == 1'b1, "R7 table absent", {resp_fault, 29'd0, resp_level}, 32'h4000_0001);
        else if (exp_f == 2'd2)
            check(resp_fault == 2'd2 && resp_level == exp_l, "R8 write denied", {resp_fault, 29'd0, resp_level}, {2'd2, 29'd0, exp_l});
        else
            check(resp_fault == 2'd0, "R8 no fault for allowed access", 32'(resp_fault), 32'd0);
        check(resp_paddr == exp_pa, exp_f != 0 ? "R12 fault address zero" :
              (pde[7] ? "R5 large page address" : "R4 page address"), resp_paddr, exp_pa);

        if (hold) begin
            @(negedge clk);
            check(resp_valid && resp_paddr == exp_pa && resp_fault == exp_f, "R10 result held",
                  resp_paddr, exp_pa);
        end
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        check(resp_valid == 1'b0 && req_ready == 1'b1, "R9 idle after result taken",
              {30'd0, resp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int tlist [6];
        tlist = '{0, 1, 2, 3, 1021, 1022};
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; resp_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        check(resp_valid == 1'b0, "R1 reset no result", 32'(resp_valid), 32'd0);
        check(mem_req_valid == 1'b0, "R1 reset no read", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < 56; k++) begin
            int d;
            d = (k < 48) ? k : 968 + k;
            for (int ti = 0; ti < 6; ti++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [11:0] off;
                    off = 12'((k * 37 + ti * 101 + w * 2047) & 12'hFFF);
                    run_walk(d, tlist[ti], off, w[0], ((k + ti + w) % 3) == 0);
                end
            end
        end
        run_walk(1023, 1023, 12'hFFF, 1'b0, 1'b1);
        run_walk(0, 1, 12'h000, 1'b1, 1'b0);

        check(addr_wobble == 0, "R11 read request held while stalled", 32'(addr_wobble), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule